// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block picks the hardware thread context that feeds instruction issue in a single-issue core. The core holds one register bank per thread. The selected thread issues every cycle that the front end asks to issue. It keeps issuing until it reports a long-latency blocking event. Three kinds of event count: a load that misses in every cache level, a wait on a message from another thread, and a wait for a DMA transfer to finish. When such an event arrives, the controller removes the thread from the ready set. On the next clock edge it moves issue to another ready thread and switches the register-bank select to match.

A blocked thread does not return to rotation when a timer expires. It returns only when its own wake input pulses, which marks the arrival of the data it was waiting for. A new thread is chosen round-robin, starting from the thread after the current one. If no thread is ready, issue is held off until some thread wakes.

Top module: `thread_switch_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every thread is ready, `cur_tid` is 0 and `bank_sel` is 1.
- R2: While the current thread is ready, `cur_tid` holds its value and `issue_valid` equals `issue_req`. Wakes of other threads do not move it.
- R3: If `stall_evt` has the bit of the current thread set while `stall_kind` is 0 (cache miss), `cur_tid` names a different ready thread from the next clock edge on.
- R4: `stall_kind` 1 (inter-thread message wait) and 2 (DMA wait) also block the thread and cause a switch. `stall_kind` 3 is not a blocking event, and the stall bits are ignored while it is applied.
- R5: The new thread is the first ready thread found when counting upward from `cur_tid`+1, wrapping from N_THREADS-1 to 0.
- R6: A blocked thread is never selected until its `wake_evt` bit has pulsed. After that it is again eligible for selection.
- R7: When the `stall_evt` and `wake_evt` bits of the same thread are both set in one cycle, the wake wins and the thread stays ready. If that thread is current, no switch happens.
- R8: When no thread is ready, `issue_valid` is 0 whatever `issue_req` is, and `cur_tid` holds.
- R9: From the idle state, a wake makes the woken thread current at the next edge, and `issue_valid` follows `issue_req` again.
- R10: `bank_sel` is always one-hot, with the single bit at position `cur_tid`.
- R11: A valid stall on a thread that is not current removes that thread from the ready set and leaves `cur_tid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_req | input | 1 | Front end wants to issue this cycle |
| stall_evt | input | N_THREADS | Per-thread blocking event report |
| stall_kind | input | 2 | Cause of the reported event (0 miss, 1 message, 2 DMA, 3 none) |
| wake_evt | input | N_THREADS | Per-thread completion (data returned) |
| cur_tid | output | TID_W | Thread that owns issue |
| bank_sel | output | N_THREADS | One-hot register-bank select |
| issue_valid | output | 1 | An instruction of `cur_tid` issues this cycle |

## Verification
Two events can meet on the same clock edge: a thread blocking itself and its own completion returning. The bench raises both bits for the current thread in one cycle. It then expects that thread to remain current and issuing rather than being switched out. A second case applies a stall to a thread that is not current and has already been woken. It then checks through a later rotation that the thread is skipped.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [1:0] {
        SK_CACHE_MISS = 2'd0,
        SK_MSG_WAIT   = 2'd1,
        SK_DMA_WAIT   = 2'd2,
        SK_NONE       = 2'd3
    } stall_kind_e;

    function automatic logic kind_blocks(input stall_kind_e k);
        case (k)
            SK_CACHE_MISS, SK_MSG_WAIT, SK_DMA_WAIT: kind_blocks = 1'b1;
            default:                                 kind_blocks = 1'b0;
        endcase
    endfunction

    function automatic int tid_width(input int n);
        tid_width = (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tsc_ready_tracker.sv
module tsc_ready_tracker #(
    parameter int N_THREADS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 block_en,
    input  logic [N_THREADS-1:0] stall_evt,
    input  logic [N_THREADS-1:0] wake_evt,
    output logic [N_THREADS-1:0] rdy_q,
    output logic [N_THREADS-1:0] rdy_next
);
    logic [N_THREADS-1:0] blk_mask;

    always_comb begin
        blk_mask = stall_evt & {N_THREADS{block_en}};
        // wake overrides a same-cycle stall on the same thread
        rdy_next = (rdy_q & ~blk_mask) | wake_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) rdy_q <= '1;
        else     rdy_q <= rdy_next;
    end

    // R7: a wake always lands in the ready set on the following edge
    a_r7_wake_wins: assert property (@(posedge clk) disable iff (rst)
        (wake_evt != '0) |=> ((rdy_q & $past(wake_evt)) == $past(wake_evt)));

    // R6: a thread that was out and got no wake stays out
    a_r6_stays_out: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rdy_q & ~$past(rdy_q) & ~$past(wake_evt)) == '0));

endmodule

// File: rtl/tsc_rr_picker.sv
module tsc_rr_picker #(
    parameter int N_THREADS = 4,
    parameter int TID_W     = 2
) (
    input  logic [TID_W-1:0]     base,
    input  logic [N_THREADS-1:0] cand,
    output logic                 found,
    output logic [TID_W-1:0]     pick
);
    always_comb begin
        found = 1'b0;
        pick  = base;
        for (int off = 1; off <= N_THREADS; off++) begin
            int idx;
            idx = (int'(base) + off) % N_THREADS;
            if (!found && cand[idx]) begin
                found = 1'b1;
                pick  = TID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/tsc_bank_decoder.sv
module tsc_bank_decoder #(
    parameter int N_THREADS = 4,
    parameter int TID_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TID_W-1:0]     tid,
    output logic [N_THREADS-1:0] bank_sel
);
    generate
        for (genvar g = 0; g < N_THREADS; g++) begin : g_bank
            assign bank_sel[g] = (tid == TID_W'(g));
        end
    endgenerate

    // R10: exactly one bank is selected
    a_r10_onehot_bank: assert property (@(posedge clk) disable iff (rst)
        $countones(bank_sel) == 1);
endmodule

// File: rtl/thread_switch_ctrl.sv
module thread_switch_ctrl
    import tsc_pkg::*;
#(
    parameter int N_THREADS = 4,
    parameter int TID_W     = tsc_pkg::tid_width(N_THREADS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_req,
    input  logic [N_THREADS-1:0] stall_evt,
    input  logic [1:0]           stall_kind,
    input  logic [N_THREADS-1:0] wake_evt,
    output logic [TID_W-1:0]     cur_tid,
    output logic [N_THREADS-1:0] bank_sel,
    output logic                 issue_valid
);
    logic                 block_en;
    logic [N_THREADS-1:0] rdy_q;
    logic [N_THREADS-1:0] rdy_next;
    logic                 pick_found;
    logic [TID_W-1:0]     pick_tid;
    logic [TID_W-1:0]     cur_q;

    assign block_en = kind_blocks(stall_kind_e'(stall_kind));

    tsc_ready_tracker #(.N_THREADS(N_THREADS)) u_track (
        .clk      (clk),
        .rst      (rst),
        .block_en (block_en),
        .stall_evt(stall_evt),
        .wake_evt (wake_evt),
        .rdy_q    (rdy_q),
        .rdy_next (rdy_next)
    );

    tsc_rr_picker #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_pick (
        .base (cur_q),
        .cand (rdy_next),
        .found(pick_found),
        .pick (pick_tid)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else if (!rdy_next[cur_q] && pick_found)
            cur_q <= pick_tid;
    end

    tsc_bank_decoder #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .tid     (cur_q),
        .bank_sel(bank_sel)
    );

    assign cur_tid     = cur_q;
    assign issue_valid = issue_req & rdy_q[cur_q];

    // R3: a blocking event on the current thread moves issue elsewhere
    a_r3_switch_on_stall: assert property (@(posedge clk) disable iff (rst)
        (block_en && stall_evt[cur_q] && !wake_evt[cur_q] && (rdy_next != '0))
            |=> (cur_tid != $past(cur_tid)));

    // R2: a thread that stays ready keeps ownership of issue
    a_r2_hold_ready: assert property (@(posedge clk) disable iff (rst)
        rdy_next[cur_q] |=> $stable(cur_tid));

    // R8: nothing issues while the ready set is empty
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (rdy_q == '0) |-> !issue_valid);

endmodule

// File: tb/sim_thread_switch_ctrl.sv
`timescale 1ns/100ps
module sim_thread_switch_ctrl;
    localparam int N  = 4;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue_req = 1'b0;
    logic [N-1:0]  stall_evt = '0;
    logic [1:0]    stall_kind = 2'd0;
    logic [N-1:0]  wake_evt = '0;
    logic [TW-1:0] cur_tid;
    logic [N-1:0]  bank_sel;
    logic          issue_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        int    tid;
        bit    v;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    thread_switch_ctrl #(.N_THREADS(N)) u0 (
        .clk(clk), .rst(rst), .issue_req(issue_req),
        .stall_evt(stall_evt), .stall_kind(stall_kind), .wake_evt(wake_evt),
        .cur_tid(cur_tid), .bank_sel(bank_sel), .issue_valid(issue_valid)
    );

    task automatic compare(input int tid, input bit v, input string tag);
        checks++;
        if (int'(cur_tid) != tid || issue_valid != v ||
            bank_sel != N'(1 << tid)) begin
            errors++;
            $display("FAIL %s: tid=%0d valid=%0b bank=%b expected tid=%0d valid=%0b bank=%b",
                     tag, cur_tid, issue_valid, bank_sel, tid, v, N'(1 << tid));
        end
    endtask

    // monitor: pops the expectation pushed for this edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            compare(e.tid, e.v, e.tag);
        end
    end

    // driver
    task automatic step(input logic [N-1:0] st, input logic [1:0] kd,
                        input logic [N-1:0] wk, input bit rq,
                        input int etid, input bit ev, input string tag);
        @(negedge clk);
        stall_evt  = st;
        stall_kind = kd;
        wake_evt   = wk;
        issue_req  = rq;
        exp_q.push_back('{etid, ev, tag});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        issue_req = 1'b1;
        #1 compare(0, 1'b1, "R1 reset state");

        step(4'b0000, 2'd0, 4'b0000, 1, 0, 1, "R2 keep issuing");
        step(4'b0001, 2'd0, 4'b0000, 1, 1, 1, "R3 R5 miss on t0 -> t1");
        step(4'b0010, 2'd1, 4'b0000, 1, 2, 1, "R4 message wait -> t2");
        step(4'b0100, 2'd2, 4'b0000, 1, 3, 1, "R4 DMA wait -> t3");
        step(4'b1000, 2'd3, 4'b0000, 1, 3, 1, "R4 kind 3 ignored");
        step(4'b0000, 2'd0, 4'b0001, 1, 3, 1, "R2 wake of other keeps t3");
        step(4'b1000, 2'd0, 4'b0000, 1, 0, 1, "R5 R6 wrap to woken t0");
        step(4'b0001, 2'd0, 4'b0001, 1, 0, 1, "R7 wake beats stall");
        step(4'b0000, 2'd0, 4'b0100, 1, 0, 1, "R6 wake t2");
        step(4'b0100, 2'd0, 4'b0000, 1, 0, 1, "R11 stall non-current t2");
        step(4'b0001, 2'd0, 4'b0000, 1, 0, 0, "R8 all blocked");
        step(4'b0000, 2'd0, 4'b0000, 1, 0, 0, "R8 idle holds");
        step(4'b0000, 2'd0, 4'b1000, 1, 3, 1, "R9 wake t3 from idle");
        step(4'b0000, 2'd0, 4'b0110, 1, 3, 1, "R2 wakes t1 t2 keep t3");
        step(4'b1000, 2'd0, 4'b0000, 1, 1, 1, "R5 R11 skip blocked t0 -> t1");
        step(4'b0000, 2'd0, 4'b0000, 0, 1, 0, "R2 valid follows req");
        step(4'b0010, 2'd0, 4'b0000, 1, 2, 1, "R3 miss on t1 -> t2");
        step(4'b0000, 2'd0, 4'b0000, 1, 2, 1, "R10 bank follows t2");

        @(negedge clk);
        stall_evt = '0;
        wake_evt  = '0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule